// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side protocol engine of a byte-addressed serial EEPROM. It oversamples the two-wire clock and data lines in the system clock domain, finds start and stop conditions, and shifts in the device-select byte, the word address and the write data. It acknowledges by enabling an open-drain pull-down on the data line and shifts read data out the same way. The engine owns the current-address counter. It serves current-address, random and sequential reads from a synchronous memory read port with one cycle of latency.

Write bytes leave the engine one at a time, together with their target address, towards a separate page-write engine. A one-cycle commit strobe at the stop condition tells that engine to start programming. While the engine reports busy, the slave stays off the bus, so a master can poll for completion by repeating start plus a write-mode device-select byte until an acknowledge comes back. The memory holds `BLOCKS` blocks of 256 bytes, with `BLOCKS` set to 1, 2, 4 or 8. Device-select bits that the address does not need are compared against hardware pins.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A start condition is a falling data line while the clock is high, and a stop condition is a rising data line while the clock is high. Out of reset, and whenever no start has been seen, the slave leaves the data line released and answers no byte.
- R2: The first byte after a start selects the device. Its top four bits must be 1010, and its bit 0 selects the direction: 1 means read and 0 means write. On a match the slave pulls the data line low during the ninth clock.
- R3: Bits 3..1 of the select byte are split by `BLOCKS`. The low log2(BLOCKS) bits of that field select the 256-byte block and become the top address bits. The remaining upper bits must equal the matching bits of `pinAddr`. With `BLOCKS`=2, bits 3..2 are compared with `pinAddr[2:1]`, and bit 1 is address bit 8.
- R4: If the select byte does not match, the slave gives no acknowledge and keeps the data line released until the next start. No later byte of that transaction is acknowledged or written.
- R5: In write mode the slave acknowledges the word address byte and each data byte. Each data byte appears for one cycle on `wrValid`, with `wrAddr` and `wrData`.
- R6: After each accepted write byte, only the low log2(PAGE_BYTES) address bits increment, wrapping within the page. The upper bits are kept.
- R7: `wrCommit` pulses for exactly one cycle at a stop condition if at least one data byte was accepted since the last start. A write-mode transaction that carries no data produces no commit.
- R8: While `engineBusy` is high, the slave ignores start conditions and does not acknowledge its address. It responds again to the first start after busy falls.
- R9: A read-mode select byte without a preceding word address returns the byte at the current counter. Reads and writes both leave the counter one past the last byte accessed.
- R10: A write-mode select byte, a word address, a repeated start and a read-mode select byte return data starting at the loaded word address, in the block chosen by the write-mode select byte.
- R11: After each read byte that the master acknowledges, the next byte follows. The read counter increments across all address bits and wraps from 2^AW-1 to 0.
- R12: When the master does not acknowledge a read byte, the slave stops driving and keeps the line released until a stop or start.
- R13: A start seen in the middle of a byte abandons that transfer and treats the next byte as a device-select byte. The counter is not loaded from a partial word address.
- R14: The slave changes its data-line drive only after a falling clock edge, a start or a stop, never while the clock is high with no condition present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired result) |
| sdaOe | output | 1 | 1 pulls the data line low |
| pinAddr | input | 3 | Hardware device-address pins |
| engineBusy | input | 1 | Page-write engine programming in progress |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | AW | Memory read address |
| memRdData | input | 8 | Read data, valid one cycle after the request |
| wrValid | output | 1 | One accepted write byte |
| wrAddr | output | AW | Address of that byte |
| wrData | output | 8 | The write byte |
| wrCommit | output | 1 | Start the program cycle |

## Verification
The bench builds the block with `BLOCKS`=2 and `PAGE_BYTES`=16, which gives a 9-bit address and one block-select bit beside two compared pin bits. This covers the mixed pin-and-block decoding, including a pin mismatch on a compared bit. Sequential reads run from the top of memory across the wrap to zero. With sixteen-byte pages, a three-byte write starting two bytes below a page boundary exercises the in-page wrap. A bench model of the page-write engine holds busy after each commit, so the polling refusal is exercised.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic savePage;
    logic loadAddr;
    logic issueRead;
    logic acceptWrite;
    logic txShift;
  } ctrl_strobe_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } bus_event_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_HOLD
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_WORD, PH_DATA, PH_READ
  } phase_t;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int BLOCKS     = 2,
  parameter int PAGE_BYTES = 16,
  localparam int AW        = 8 + $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [2:0]    pinAddr,
  input  ctrl_strobe_t  strb,
  input  logic [7:0]    memRdData,
  output bus_event_t    ev,
  output logic          devHit,
  output logic          rwBit,
  output logic          txBit,
  output logic          memRdEn,
  output logic [AW-1:0] memRdAddr,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData
);
  localparam int PB  = $clog2(BLOCKS);
  localparam int PGB = $clog2(PAGE_BYTES);
  localparam logic [2:0]     PIN_MASK = 3'b111 << PB;
  localparam logic [AW-1:0]  AW_ONE   = 1;
  localparam logic [PGB-1:0] PG_ONE   = 1;

  logic [1:0]    sclSync, sdaSync;
  logic          sclQ, sdaQ;
  logic          sclS, sdaS;
  logic [7:0]    shReg, txReg;
  logic          rdPend;
  logic [AW-1:0] addrCnt, loadVal, nextWr;

  // two-flop synchronizers plus one history stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  assign ev.sclRise   = sclS & ~sclQ;
  assign ev.sclFall   = ~sclS & sclQ;
  assign ev.startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign ev.stopSeen  = sclS & sclQ & ~sdaQ & sdaS;
  assign ev.sdaBit    = sdaS;

  assign devHit = (shReg[7:4] == 4'b1010) && (((shReg[3:1] ^ pinAddr) & PIN_MASK) == 3'b000);
  assign rwBit  = shReg[0];
  assign txBit  = txReg[7];

  // block-select bits exist only when there is more than one block
  generate
    if (PB == 0) begin : g_noPage
      logic unusedSave;
      assign unusedSave = strb.savePage;
      assign loadVal    = shReg;
    end else begin : g_page
      logic [PB-1:0] pageReg;
      always_ff @(posedge clk) begin
        if (!rstN)              pageReg <= '0;
        else if (strb.savePage) pageReg <= shReg[PB:1];
      end
      assign loadVal = {pageReg, shReg};
    end
  endgenerate

  assign nextWr    = {addrCnt[AW-1:PGB], addrCnt[PGB-1:0] + PG_ONE};
  assign memRdEn   = strb.issueRead;
  assign memRdAddr = addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      txReg   <= '1;
      rdPend  <= 1'b0;
      addrCnt <= '0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      rdPend  <= strb.issueRead;
      wrValid <= strb.acceptWrite;
      if (strb.shiftIn) shReg <= {shReg[6:0], sdaS};
      if (rdPend)            txReg <= memRdData;
      else if (strb.txShift) txReg <= {txReg[6:0], 1'b1};
      if (strb.loadAddr)         addrCnt <= loadVal;
      else if (strb.issueRead)   addrCnt <= addrCnt + AW_ONE;
      else if (strb.acceptWrite) addrCnt <= nextWr;
      if (strb.acceptWrite) begin
        wrAddr <= addrCnt;
        wrData <= shReg;
      end
    end
  end

  p_rd_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (addrCnt == $past(addrCnt) + AW_ONE));

  p_wr_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.acceptWrite |=> (wrValid && addrCnt[AW-1:PGB] == $past(addrCnt[AW-1:PGB])));

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  bus_event_t   ev,
  input  logic         devHit,
  input  logic         rwBit,
  input  logic         txBit,
  input  logic         engineBusy,
  output ctrl_strobe_t strb,
  output logic         sdaOe,
  output logic         wrCommit
);
  eng_state_t st, nSt;
  phase_t     ph, nPh;
  logic [3:0] cnt, nCnt;
  logic       oe, nOe, wrote, nWrote, nCommit;

  always_comb begin
    nSt     = st;
    nPh     = ph;
    nCnt    = cnt;
    nOe     = oe;
    nWrote  = wrote;
    nCommit = 1'b0;
    strb    = '0;
    if (ev.stopSeen) begin
      nSt     = S_IDLE;
      nOe     = 1'b0;
      nCommit = wrote;
      nWrote  = 1'b0;
    end else if (ev.startSeen && !engineBusy) begin
      nSt    = S_RX;
      nPh    = PH_DEV;
      nCnt   = 4'd0;
      nOe    = 1'b0;
      nWrote = 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (ev.sclRise) begin
            strb.shiftIn = 1'b1;
            nCnt = cnt + 4'd1;
          end else if (ev.sclFall && cnt == 4'd8) begin
            case (ph)
              PH_DEV: begin
                if (devHit && !engineBusy) begin
                  nOe = 1'b1;
                  nSt = S_ACK;
                  if (rwBit) begin
                    nPh = PH_READ;
                    strb.issueRead = 1'b1;
                  end else begin
                    nPh = PH_WORD;
                    strb.savePage = 1'b1;
                  end
                end else begin
                  nSt = S_HOLD;
                end
              end
              PH_WORD: begin
                nOe = 1'b1;
                nSt = S_ACK;
                nPh = PH_DATA;
                strb.loadAddr = 1'b1;
              end
              default: begin
                nOe    = 1'b1;
                nSt    = S_ACK;
                nWrote = 1'b1;
                strb.acceptWrite = 1'b1;
              end
            endcase
          end
        end
        S_ACK: begin
          if (ev.sclFall) begin
            if (ph == PH_READ) begin
              nOe  = ~txBit;
              nCnt = 4'd1;
              nSt  = S_TX;
              strb.txShift = 1'b1;
            end else begin
              nOe  = 1'b0;
              nCnt = 4'd0;
              nSt  = S_RX;
            end
          end
        end
        S_TX: begin
          if (ev.sclFall) begin
            if (cnt == 4'd8) begin
              nOe = 1'b0;
              nSt = S_RACK;
            end else begin
              nOe  = ~txBit;
              nCnt = cnt + 4'd1;
              strb.txShift = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (ev.sclRise) begin
            if (!ev.sdaBit) begin
              strb.issueRead = 1'b1;
              nCnt = 4'd0;
              nSt  = S_TX;
            end else begin
              nSt = S_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      ph       <= PH_DEV;
      cnt      <= '0;
      oe       <= 1'b0;
      wrote    <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      st       <= nSt;
      ph       <= nPh;
      cnt      <= nCnt;
      oe       <= nOe;
      wrote    <= nWrote;
      wrCommit <= nCommit;
    end
  end

  assign sdaOe = oe;

  p_drive_on_fall_r14: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oe) |-> $past(ev.sclFall || ev.startSeen || ev.stopSeen));

  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && engineBusy) |=> (st == S_IDLE));

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_HOLD) |-> !oe);

  p_ack_driven_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_ACK) |-> oe);

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
  import eeprom_pkg::*;
#(
  parameter int BLOCKS     = 2,
  parameter int PAGE_BYTES = 16,
  localparam int AW        = 8 + $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sdaOe,
  input  logic [2:0]    pinAddr,
  input  logic          engineBusy,
  output logic          memRdEn,
  output logic [AW-1:0] memRdAddr,
  input  logic [7:0]    memRdData,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic          wrCommit
);
  ctrl_strobe_t strb;
  bus_event_t   ev;
  logic         devHit, rwBit, txBit;

  eeprom_datapath #(.BLOCKS(BLOCKS), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .pinAddr(pinAddr),
    .strb(strb), .memRdData(memRdData), .ev(ev), .devHit(devHit), .rwBit(rwBit),
    .txBit(txBit), .memRdEn(memRdEn), .memRdAddr(memRdAddr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  eeprom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .devHit(devHit), .rwBit(rwBit), .txBit(txBit),
    .engineBusy(engineBusy), .strb(strb), .sdaOe(sdaOe), .wrCommit(wrCommit)
  );

endmodule

// File: tb/eeprom_bus_slave_bench.sv
module eeprom_bus_slave_bench;
  localparam int BLK = 2;
  localparam int AW  = 9;
  localparam int DEPTH = 512;
  localparam int H = 8;
  localparam int BUSY_CYCLES = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic busSda;
  logic sdaOe, memRdEn, wrValid, wrCommit;
  logic [AW-1:0] memRdAddr, wrAddr;
  logic [7:0] memRdData, wrData;
  logic engineBusy;
  logic [2:0] pinAddr = 3'b110;

  int checks = 0, failures = 0, commitCnt = 0, busyCnt = 0;
  bit done = 0;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] pAddr [16];
  logic [7:0] pData [16];
  int pendN = 0;
  logic [AW+7:0] wrQ [$];

  always #2 clk = ~clk;
  assign busSda = mSda & ~sdaOe;
  assign engineBusy = (busyCnt != 0);

  eeprom_bus_slave #(.BLOCKS(BLK), .PAGE_BYTES(16)) u_eeprom_bus_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaOe(sdaOe),
    .pinAddr(pinAddr), .engineBusy(engineBusy), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );

  // memory and page-write engine model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + (i >> 8) * 91 + 11);
      memRdData <= '0;
      busyCnt = 0;
      pendN = 0;
    end else begin
      if (memRdEn) memRdData <= mem[memRdAddr];
      if (wrValid) begin
        pAddr[pendN % 16] = wrAddr;
        pData[pendN % 16] = wrData;
        pendN++;
      end
      if (wrCommit) begin
        commitCnt++;
        for (int k = 0; k < pendN && k < 16; k++) mem[pAddr[k]] = pData[k];
        pendN = 0;
        busyCnt = BUSY_CYCLES;
      end else if (busyCnt > 0) begin
        busyCnt--;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for write bytes
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (wrQ.size() == 0) begin
        check(1'b0, "R5 unexpected write byte", int'({wrAddr, wrData}), 0);
      end else begin
        logic [AW+7:0] e;
        e = wrQ.pop_front();
        check({wrAddr, wrData} == e, "R5/R6 write byte", int'({wrAddr, wrData}), int'(e));
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitClk(input logic b, output logic seen);
    mSda = b;
    waitClk(H);
    mScl = 1'b1;
    waitClk(H / 2);
    seen = busSda;
    waitClk(H / 2);
    mScl = 1'b0;
    waitClk(2);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitClk(b[i], s);
    bitClk(1'b1, s);
    ack = ~s;
  endtask

  task automatic readCheck(input bit ackIt, input int addr, input string tag);
    logic s;
    logic [7:0] v = '0;
    logic [7:0] e = mem[addr];
    for (int i = 0; i < 8; i++) begin
      bitClk(1'b1, s);
      v = {v[6:0], s};
    end
    bitClk(~ackIt, s);
    check(v == e, tag, int'(v), int'(e));
  endtask

  function automatic logic [7:0] devByte(input bit page, input bit rd);
    return {4'b1010, 2'b11, page, rd};
  endfunction

  initial begin
    logic ack, s;
    int c0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check(sdaOe == 1'b0 && wrValid == 1'b0 && wrCommit == 1'b0, "R1 reset outputs", int'(sdaOe), 0);

    // R1: address bits without a start are not answered
    sendByte(devByte(0, 0), ack);
    check(ack == 1'b0, "R1 no start no ack", int'(ack), 0);

    // R2/R3/R4: mismatches
    busStart(); sendByte(8'b1011_1100, ack);
    check(ack == 1'b0, "R2 wrong device type", int'(ack), 0);
    sendByte(8'h55, ack);
    check(ack == 1'b0, "R4 later byte ignored", int'(ack), 0);
    busStop();
    busStart(); sendByte(8'b1010_0100, ack);
    check(ack == 1'b0, "R3 compared pin bit mismatch", int'(ack), 0);
    busStop();

    // R5/R3: byte write to block 1, word 0x20
    c0 = commitCnt;
    busStart(); sendByte(devByte(1, 0), ack);
    check(ack == 1'b1, "R2 address ack", int'(ack), 1);
    sendByte(8'h20, ack);
    check(ack == 1'b1, "R5 word address ack", int'(ack), 1);
    wrQ.push_back({9'h120, 8'hA5});
    sendByte(8'hA5, ack);
    check(ack == 1'b1, "R5 data ack", int'(ack), 1);
    busStop();
    check(commitCnt == c0 + 1, "R7 commit on stop", commitCnt, c0 + 1);

    // R8: polling while busy
    check(engineBusy == 1'b1, "R8 engine busy", int'(engineBusy), 1);
    busStart(); sendByte(devByte(0, 0), ack);
    check(ack == 1'b0, "R8 no ack while busy", int'(ack), 0);
    busStop();
    wait (engineBusy == 1'b0);
    waitClk(4);
    c0 = commitCnt;
    busStart(); sendByte(devByte(0, 0), ack);
    check(ack == 1'b1, "R8 ack after busy", int'(ack), 1);
    busStop();
    waitClk(4);
    check(commitCnt == c0, "R7 no commit without data", commitCnt, c0);

    // R9: current-address reads after the write at 0x120
    busStart(); sendByte(devByte(0, 1), ack);
    check(ack == 1'b1, "R2 read address ack", int'(ack), 1);
    readCheck(0, 9'h121, "R9 current read after write");
    busStop();
    busStart(); sendByte(devByte(0, 1), ack);
    readCheck(0, 9'h122, "R9 current read after read");
    busStop();

    // R10/R11/R12: random then sequential read in block 0
    busStart(); sendByte(devByte(0, 0), ack); sendByte(8'h40, ack);
    busStart(); sendByte(devByte(0, 1), ack);
    check(ack == 1'b1, "R10 repeated start ack", int'(ack), 1);
    readCheck(1, 9'h040, "R10 random read");
    readCheck(1, 9'h041, "R11 sequential read 2");
    readCheck(0, 9'h042, "R11 sequential read 3");
    c0 = 0;
    for (int i = 0; i < 9; i++) begin
      bitClk(1'b1, s);
      if (!s) c0++;
    end
    check(c0 == 0 && sdaOe == 1'b0, "R12 released after nack", c0, 0);
    busStop();

    // R11: wrap from top of memory to zero
    busStart(); sendByte(devByte(1, 0), ack); sendByte(8'hFF, ack);
    busStart(); sendByte(devByte(0, 1), ack);
    readCheck(1, 9'h1FF, "R11 top byte");
    readCheck(0, 9'h000, "R11 wrap to zero");
    busStop();

    // R6: page write across a page boundary
    c0 = commitCnt;
    busStart(); sendByte(devByte(0, 0), ack); sendByte(8'hFE, ack);
    wrQ.push_back({9'h0FE, 8'h11}); sendByte(8'h11, ack);
    wrQ.push_back({9'h0FF, 8'h22}); sendByte(8'h22, ack);
    wrQ.push_back({9'h0F0, 8'h33}); sendByte(8'h33, ack);
    check(ack == 1'b1, "R5 third data ack", int'(ack), 1);
    busStop();
    check(commitCnt == c0 + 1, "R7 page commit", commitCnt, c0 + 1);
    wait (engineBusy == 1'b0);
    waitClk(4);
    busStart(); sendByte(devByte(0, 1), ack);
    readCheck(0, 9'h0F1, "R6 counter wrapped within page");
    busStop();
    busStart(); sendByte(devByte(0, 0), ack); sendByte(8'hF0, ack);
    busStart(); sendByte(devByte(0, 1), ack);
    check(mem[9'h0F0] == 8'h33, "R6 wrapped byte stored", int'(mem[9'h0F0]), 8'h33);
    readCheck(0, 9'h0F0, "R10 read of wrapped byte");
    busStop();

    // R13: start in the middle of a word address byte; counter now 0x0F1
    busStart(); sendByte(devByte(1, 0), ack);
    for (int i = 0; i < 4; i++) bitClk(1'b0, s);
    busStart(); sendByte(devByte(0, 1), ack);
    check(ack == 1'b1, "R13 address after abort", int'(ack), 1);
    readCheck(0, 9'h0F1, "R13 counter not loaded");
    busStop();

    waitClk(10);
    check(wrQ.size() == 0, "R5 all writes seen", wrQ.size(), 0);
    check(sdaOe == 1'b0, "R14 idle released", int'(sdaOe), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule